// File: doc/BRIEF.md
# Binary-to-Decimal Converter by Fractional Scaling

This block turns an unsigned binary integer (64 bits by default) into its full decimal form: a stream of ASCII digit characters, most significant digit first, always zero-padded to 20 characters. It uses no divider. The input is first multiplied by a fixed constant, about 2^64/10^19 rounded upward. That step places the value x/10^19 in a fixed-point register, with the leading digit in the integer part. Every later digit is obtained by clearing the integer part and multiplying the remaining fraction by ten. The integer that spills out of that multiply is the next digit.

A requester offers a value with `start_i` while `ready_o` is high. The constant multiply is done serially, one input chunk per cycle. After it, one character comes out per cycle with a valid strobe, and the twentieth character carries a last flag. The fraction register keeps every product bit together with the extra guard bits of the constant. The digits are therefore exact for every input, including those with long runs of trailing zeros or nines.

Top module: `b2d_convert`

## Requirements
- R1: A synchronous active-high reset returns the block to idle within one clock: `ready_o` = 1, `char_valid_o` = 0, `char_last_o` = 0.
- R2: A conversion is accepted at a rising edge where `start_i` = 1 and `ready_o` = 1, and `ready_o` is 0 in the cycle after that edge.
- R3: Counting the accepting edge as edge 0, the first character is presented after edge IN_W/CHUNK_W+1 (edge 9 by default), and `char_valid_o` then stays high for exactly 20 consecutive cycles.
- R4: Each character equals 0x30 plus one decimal digit. The 20 characters are the input written in decimal, zero-padded on the left, with the most significant digit first.
- R5: `char_last_o` is 1 together with the 20th character only (after edge 28 by default) and 0 at all other times.
- R6: In the cycle after the last character, `char_valid_o` is 0 and `ready_o` is 1 again.
- R7: `start_i` has no effect while `ready_o` is 0. The character stream of the running conversion is unchanged, and no further conversion follows it.
- R8: The first character of every conversion is 0x30 or 0x31.
- R9: Conversion is exact for the boundary values 0, 1, 2^64-1, every power of ten 10^k, and every 10^k-1.
- R10: Every character presented with `char_valid_o` = 1 lies in the range 0x30 to 0x39.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to convert `value_i` |
| value_i | input | IN_W (64) | Unsigned binary value to convert |
| ready_o | output | 1 | High when a new request can be accepted |
| char_o | output | 8 | ASCII decimal digit |
| char_valid_o | output | 1 | `char_o` holds a digit this cycle |
| char_last_o | output | 1 | Marks the 20th (least significant) digit |

## Verification
Two events can fall in the same cycle. A new request can arrive while a conversion is still running, including the cycle of its last character, and a request can arrive on the very cycle that `ready_o` returns. The bench holds `start_i` high with a different value from the first cycle of a conversion through its last character. The stream must still match the first value, and no second stream may appear while the bench watches the idle cycles that follow. A separate run keeps a request pending at the moment `ready_o` rises, and the bench checks that it is taken on that edge and converted correctly.

// File: rtl/b2d_pkg.sv
package b2d_pkg;

  // Width of the scratch vectors used by the elaboration-time math.
  localparam int MAXW = 256;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_EMIT,
    ST_FIN
  } b2d_state_e;

  // 10^k as a wide vector.
  function automatic logic [MAXW-1:0] pow10(input int k);
    logic [MAXW-1:0] p;
    p = MAXW'(1);
    for (int i = 0; i < k; i++) p = p * MAXW'(10);
    return p;
  endfunction

  // Number of decimal digits needed for the largest in_w-bit value.
  function automatic int dec_digits(input int in_w);
    logic [MAXW-1:0] lim;
    logic [MAXW-1:0] p;
    int n;
    lim = (MAXW'(1) << in_w) - MAXW'(1);
    p   = MAXW'(1);
    n   = 0;
    for (int i = 0; i < 80; i++) begin
      if (p <= lim) begin
        p = p * MAXW'(10);
        n = n + 1;
      end
    end
    return n;
  endfunction

  // ceil(2^(in_w+frac_w) / 10^(digits-1)): the scale constant with frac_w
  // fraction bits, rounded upward so the scaled value never falls short.
  function automatic logic [MAXW-1:0] scale_const(input int in_w, input int frac_w,
                                                  input int digits);
    logic [MAXW-1:0] num;
    logic [MAXW-1:0] den;
    logic [MAXW-1:0] q;
    num = MAXW'(1) << (in_w + frac_w);
    den = pow10(digits - 1);
    q   = num / den;
    if (q * den != num) q = q + MAXW'(1);
    return q;
  endfunction

endpackage

// File: rtl/b2d_scale_mul.sv
// Serial constant multiplier: Horner accumulation over CHUNK_W-bit input
// slices, most significant slice first. acc = (acc << CHUNK_W) + slice*K.
module b2d_scale_mul #(
  parameter int IN_W    = 64,
  parameter int CHUNK_W = 8,
  parameter int K_W     = 76,
  parameter int ACC_W   = 140,
  parameter logic [K_W-1:0] SCALE = '0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [IN_W-1:0]  x_i,
  input  logic             step_i,
  output logic [ACC_W-1:0] acc_o
);

  localparam int PP_W = CHUNK_W + K_W;

  logic [IN_W-1:0]    sh_q;
  logic [ACC_W-1:0]   acc_q;
  logic [CHUNK_W-1:0] slice;
  logic [PP_W-1:0]    partial;

  assign slice = sh_q[IN_W-1 -: CHUNK_W];

  generate
    if (CHUNK_W == 1) begin : g_bitserial
      // One bit per cycle: the partial product is a plain select.
      assign partial = slice[0] ? PP_W'(SCALE) : '0;
    end else begin : g_chunked
      // Several bits per cycle: narrow-by-wide product.
      assign partial = PP_W'(slice) * PP_W'(SCALE);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sh_q  <= '0;
      acc_q <= '0;
    end else if (load_i) begin
      sh_q  <= x_i;
      acc_q <= '0;
    end else if (step_i) begin
      sh_q  <= sh_q << CHUNK_W;
      acc_q <= (acc_q << CHUNK_W) + ACC_W'(partial);
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/b2d_dec_step.sv
// One digit extraction: the integer field above FRAC_W bits is the digit;
// the fraction alone, times ten by shift-add, is the next working value.
module b2d_dec_step #(
  parameter int WORK_W = 140,
  parameter int FRAC_W = 136
) (
  input  logic [WORK_W-1:0] work_i,
  output logic [3:0]        digit_o,
  output logic [WORK_W-1:0] next_o
);

  logic [WORK_W-1:0] frac;

  assign digit_o = work_i[WORK_W-1 -: 4];
  assign frac    = {{(WORK_W-FRAC_W){1'b0}}, work_i[FRAC_W-1:0]};
  assign next_o  = (frac << 3) + (frac << 1);

endmodule

// File: rtl/b2d_char_out.sv
// Registered character port: ASCII encoding plus valid and last strobes.
module b2d_char_out (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       emit_i,
  input  logic       last_i,
  input  logic [3:0] digit_i,
  output logic [7:0] char_o,
  output logic       valid_o,
  output logic       last_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      char_o  <= 8'h30;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      if (emit_i) char_o <= {4'h3, digit_i};
      valid_o <= emit_i;
      last_o  <= emit_i & last_i;
    end
  end

endmodule

// File: rtl/b2d_convert.sv
module b2d_convert
  import b2d_pkg::*;
#(
  parameter int IN_W    = 64,
  parameter int CHUNK_W = 8,
  parameter int GUARD_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            start_i,
  input  logic [IN_W-1:0] value_i,
  output logic            ready_o,
  output logic [7:0]      char_o,
  output logic            char_valid_o,
  output logic            char_last_o
);

  localparam int DIGITS = dec_digits(IN_W);
  localparam int CF     = IN_W + GUARD_W;   // fraction bits of the constant
  localparam int PF     = IN_W + CF;        // fraction bits of the product
  localparam int K_W    = CF + 4;
  localparam int WORK_W = PF + 4;
  localparam int NCH    = IN_W / CHUNK_W;
  localparam int CNT_W  = $clog2(NCH + 1);
  localparam int DIG_W  = $clog2(DIGITS + 1);
  localparam logic [MAXW-1:0] SCALE_FULL = scale_const(IN_W, CF, DIGITS);
  localparam logic [K_W-1:0]  SCALE      = SCALE_FULL[K_W-1:0];

  b2d_state_e        state_q;
  logic              ready_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DIG_W-1:0]  dig_q;
  logic [WORK_W-1:0] work_q;
  logic [WORK_W-1:0] acc;
  logic [WORK_W-1:0] step_in;
  logic [WORK_W-1:0] step_next;
  logic [3:0]        digit;
  logic              mul_load;
  logic              mul_step;
  logic              emit;
  logic              last_dig;

  assign mul_load = (state_q == ST_IDLE) && start_i && ready_q;
  assign mul_step = (state_q == ST_MUL);
  assign emit     = (state_q == ST_EMIT);
  assign last_dig = (dig_q == DIG_W'(DIGITS - 1));
  assign step_in  = (dig_q == '0) ? acc : work_q;

  b2d_scale_mul #(
    .IN_W    (IN_W),
    .CHUNK_W (CHUNK_W),
    .K_W     (K_W),
    .ACC_W   (WORK_W),
    .SCALE   (SCALE)
  ) u_mul (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (mul_load),
    .x_i    (value_i),
    .step_i (mul_step),
    .acc_o  (acc)
  );

  b2d_dec_step #(
    .WORK_W (WORK_W),
    .FRAC_W (PF)
  ) u_step (
    .work_i  (step_in),
    .digit_o (digit),
    .next_o  (step_next)
  );

  b2d_char_out u_out (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .emit_i  (emit),
    .last_i  (last_dig),
    .digit_i (digit),
    .char_o  (char_o),
    .valid_o (char_valid_o),
    .last_o  (char_last_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b1;
      cnt_q   <= '0;
      dig_q   <= '0;
      work_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (mul_load) begin
            state_q <= ST_MUL;
            ready_q <= 1'b0;
            cnt_q   <= '0;
          end
        end
        ST_MUL: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(NCH - 1)) begin
            state_q <= ST_EMIT;
            dig_q   <= '0;
          end
        end
        ST_EMIT: begin
          work_q <= step_next;
          dig_q  <= dig_q + DIG_W'(1);
          if (last_dig) state_q <= ST_FIN;
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
          ready_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = ready_q;

endmodule

// File: rtl/b2d_convert_chk.sv
module b2d_convert_chk #(
  parameter int DIGITS = 20
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       start_i,
  input logic       ready_o,
  input logic [7:0] char_o,
  input logic       char_valid_o,
  input logic       char_last_o
);

  logic [7:0] pos_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)             pos_q <= '0;
    else if (char_valid_o) pos_q <= char_last_o ? 8'd0 : pos_q + 8'd1;
  end

  a_r1_reset_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (ready_o && !char_valid_o && !char_last_o));

  a_r2_accept_drops_ready: assert property (@(posedge clk_i) disable iff (rst_i)
    (ready_o && start_i) |=> !ready_o);

  a_r3_back_to_back: assert property (@(posedge clk_i) disable iff (rst_i)
    (char_valid_o && !char_last_o) |=> char_valid_o);

  a_r3_count: assert property (@(posedge clk_i) disable iff (rst_i)
    char_last_o |-> (pos_q == 8'(DIGITS - 1)));

  a_r5_last_with_valid: assert property (@(posedge clk_i) disable iff (rst_i)
    char_last_o |-> char_valid_o);

  a_r6_ready_after_last: assert property (@(posedge clk_i) disable iff (rst_i)
    char_last_o |=> (ready_o && !char_valid_o));

  a_r7_busy_not_ready: assert property (@(posedge clk_i) disable iff (rst_i)
    char_valid_o |-> !ready_o);

  a_r8_msd_range: assert property (@(posedge clk_i) disable iff (rst_i)
    (char_valid_o && pos_q == 8'd0) |-> (char_o <= 8'h31));

  a_r10_ascii_range: assert property (@(posedge clk_i) disable iff (rst_i)
    char_valid_o |-> (char_o >= 8'h30 && char_o <= 8'h39));

endmodule

bind b2d_convert b2d_convert_chk #(.DIGITS(DIGITS)) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .start_i      (start_i),
  .ready_o      (ready_o),
  .char_o       (char_o),
  .char_valid_o (char_valid_o),
  .char_last_o  (char_last_o)
);

// File: tb/sim_b2d_convert.sv
module sim_b2d_convert;

  localparam int ND      = 20;
  localparam int FIRST_E = 64 / 8 + 1;
  localparam int LAST_E  = FIRST_E + ND - 1;
  localparam int NVEC    = 8;
  localparam logic [63:0] VEC [NVEC] = '{
    64'd0,
    64'd1,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'd12345678901234567890,
    64'h8000_0000_0000_0000,
    64'd10000000000000000000,
    64'd9999999999999999999,
    64'd500000000000000005
  };

  logic        clk = 1'b0;
  logic        rst_i = 1'b1;
  logic        start_i = 1'b0;
  logic [63:0] value_i = '0;
  logic        ready_o;
  logic [7:0]  char_o;
  logic        char_valid_o;
  logic        char_last_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0] exp_c [ND];
  logic [7:0] got_c [ND];

  always #2 clk = ~clk;

  b2d_convert u0 (
    .clk_i        (clk),
    .rst_i        (rst_i),
    .start_i      (start_i),
    .value_i      (value_i),
    .ready_o      (ready_o),
    .char_o       (char_o),
    .char_valid_o (char_valid_o),
    .char_last_o  (char_last_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Reference: repeated division by ten, zero-padded, MSD at index 0.
  task automatic ref_digits(input logic [63:0] x);
    logic [63:0] v;
    v = x;
    for (int i = ND - 1; i >= 0; i--) begin
      exp_c[i] = 8'h30 + 8'(v % 64'd10);
      v = v / 64'd10;
    end
  endtask

  // One conversion. With hold set, start_i stays high with 'other' from the
  // cycle after acceptance through the last character (R7).
  task automatic run_conv(input logic [63:0] x, input string req,
                          input bit hold, input logic [63:0] other);
    int n, first_e, last_e, nlast, bad_i;
    bit range_ok;
    ref_digits(x);
    n = 0; first_e = -1; last_e = -1; nlast = 0; bad_i = -1; range_ok = 1'b1;
    while (!ready_o) @(negedge clk);
    start_i = 1'b1;
    value_i = x;
    @(posedge clk);
    @(negedge clk);
    check(!ready_o, "R2", "ready after accept", 64'(ready_o), 64'd0);
    if (hold) value_i = other;
    else start_i = 1'b0;
    for (int e = 1; e <= 40; e++) begin
      @(negedge clk);
      if (char_valid_o) begin
        if (first_e < 0) first_e = e;
        if (n < ND) got_c[n] = char_o;
        if (char_o < 8'h30 || char_o > 8'h39) range_ok = 1'b0;
        n++;
      end
      if (char_last_o) begin
        nlast++;
        last_e = e;
        break;
      end
    end
    check(first_e == FIRST_E, "R3", "first char edge", 64'(first_e), 64'(FIRST_E));
    check(n == ND, "R3", "char count", 64'(n), 64'(ND));
    check(last_e == LAST_E && nlast == 1, "R5", "last flag edge", 64'(last_e), 64'(LAST_E));
    check(range_ok, "R10", "char range", 64'(range_ok), 64'd1);
    if (n == ND) begin
      for (int i = 0; i < ND; i++)
        if (bad_i < 0 && got_c[i] != exp_c[i]) bad_i = i;
      check(bad_i < 0, req, "digit string", (bad_i < 0) ? 64'd0 : 64'(got_c[bad_i]),
            (bad_i < 0) ? 64'd0 : 64'(exp_c[bad_i]));
      check(got_c[0] <= 8'h31, "R8", "leading char", 64'(got_c[0]), 64'h31);
    end
    @(negedge clk);
    check(ready_o && !char_valid_o, "R6", "ready/valid after last",
          {62'd0, ready_o, char_valid_o}, 64'd2);
    if (hold) begin
      start_i = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        check(ready_o && !char_valid_o, "R7", "no conversion from held start",
              {62'd0, ready_o, char_valid_o}, 64'd2);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [63:0] p;
    // Reset state (R1)
    repeat (3) @(negedge clk);
    rst_i = 1'b0;
    @(negedge clk);
    check(ready_o && !char_valid_o && !char_last_o, "R1", "idle after reset",
          {61'd0, ready_o, char_valid_o, char_last_o}, 64'd4);

    // Vector table (R4, R9)
    for (int i = 0; i < NVEC; i++) run_conv(VEC[i], "R4", 1'b0, 64'd0);

    // Powers of ten and all-nines values (R9)
    p = 64'd1;
    for (int k = 0; k < ND; k++) begin
      run_conv(p, "R9", 1'b0, 64'd0);
      if (k > 0) run_conv(p - 64'd1, "R9", 1'b0, 64'd0);
      if (k < ND - 1) p = p * 64'd10;
    end

    // Random values of varying magnitude (R4)
    for (int i = 0; i < 60; i++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      r = r >> ($urandom % 64);
      run_conv(r, "R4", 1'b0, 64'd0);
    end

    // Start held high during a whole conversion, including the last-char cycle (R7)
    run_conv(64'd7777777777777777777, "R7", 1'b1, 64'd1234);

    // Request pending when ready returns is accepted on that edge (R2)
    start_i = 1'b1;
    value_i = 64'd42;
    run_conv(64'd42, "R2", 1'b0, 64'd0);
    run_conv(64'd18000000000000000001, "R2", 1'b0, 64'd0);

    // Reset in the middle of a conversion (R1)
    @(negedge clk);
    start_i = 1'b1;
    value_i = 64'd999;
    @(negedge clk);
    start_i = 1'b0;
    repeat (12) @(negedge clk);
    rst_i = 1'b1;
    @(negedge clk);
    rst_i = 1'b0;
    check(ready_o && !char_valid_o && !char_last_o, "R1", "idle after mid reset",
          {61'd0, ready_o, char_valid_o, char_last_o}, 64'd4);
    repeat (3) @(negedge clk);
    check(!char_valid_o, "R1", "no stream after mid reset", 64'(char_valid_o), 64'd0);
    run_conv(64'd31415926535897932, "R4", 1'b0, 64'd0);

    finish_up();
  end

endmodule